// File: doc/BRIEF.md
# Vector Page Remap Unit

This unit sits on the fetch path between a processor and its memories. It redirects any access to the lowest 512-byte page of the address space (byte addresses 0x000 to 0x1FF) to another page. The destination page comes from a 21-bit map field held inside the unit. The remapped address is the map field placed above the nine low-order bits of the incoming address. The two top bits of the field say whether that page lives in flash or in SRAM. An access that falls outside the low page, or that is flagged as belonging to the secure region, goes through unchanged.

The map field changes only through a remap command, given as a one-cycle strobe together with a target byte address. The unit checks the target before loading it. The target must be page aligned, its reserved bits must be zero, and its memory selector must be one of the two legal codes. A target that passes is loaded into the map field. A target that fails leaves the field as it was and raises a one-cycle fail pulse. The map field can be read back at any time through a status word.

Top module: `vector_remap`

## Requirements
- R1: After reset the map field is zero. The low page then maps onto itself, `status_word` is 0 and `cmd_fail` is 0.
- R2: When `bus_addr[31:9]` is zero and `secure_hit` is 0, `out_addr` equals {2'b00, field[20:0], bus_addr[8:0]} in the same cycle.
- R3: When `bus_addr[31:9]` is nonzero, `out_addr` equals `bus_addr` and `out_sram` is 0.
- R4: When `secure_hit` is 1, `out_addr` equals `bus_addr` and `out_sram` is 0, even for an address inside the low page.
- R5: For a remapped access, `out_sram` is 1 when field[20:19] is 2'b10 and 0 when it is 2'b00.
- R6: A command whose target passes every check loads field = `cmd_addr[29:9]` at the clock edge where `cmd_valid` is sampled. `cmd_fail` stays 0 in the following cycle.
- R7: A command whose target has any of bits [8:0] set is rejected. The field is unchanged and `cmd_fail` is 1 for exactly the next cycle.
- R8: A command whose target has any of bits [27:21] (field bits 18:12) or bits [31:30] set is rejected, with the same effect as in R7.
- R9: A command whose target has bit 28 set (field[20:19] equal to 01 or 11) is rejected, with the same effect as in R7.
- R10: `status_word` shows the field at bits [29:9]. All other bits of `status_word` are zero.
- R11: `cmd_fail` is 0 in any cycle that does not directly follow a rejected command, and the field does not change without a command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 32 | Byte address of the current fetch |
| secure_hit | input | 1 | Current fetch targets the secure region; remapping is bypassed |
| cmd_valid | input | 1 | One-cycle remap command strobe |
| cmd_addr | input | 32 | Target byte address of the remap command |
| out_addr | output | 32 | Translated address |
| out_sram | output | 1 | Translated access goes to SRAM (1) or flash (0) |
| cmd_fail | output | 1 | One-cycle pulse after a rejected command |
| status_word | output | 32 | Map field read back at bits [29:9] |

## Verification
The assertions assume that `cmd_valid` is a clean, synchronous strobe and that `cmd_addr` is stable whenever the strobe is high. They also assume that `secure_hit` is settled in the same cycle as `bus_addr`. The bench drives every input on the falling clock edge and holds it for a full cycle. It raises `cmd_valid` for exactly one cycle per command and keeps `bus_addr` and `secure_hit` steady while a command is in flight, so each observation reflects only one change.

// File: rtl/vrm_pkg.sv
package vrm_pkg;
  localparam int ADDR_W  = 32;
  localparam int PAGE_W  = 9;
  localparam int FIELD_W = 21;
  localparam int RSV_LO  = 12;
  localparam int RSV_HI  = 18;
  localparam int PAD_W   = ADDR_W - FIELD_W - PAGE_W;

  typedef enum logic [1:0] {
    MEM_FLASH = 2'b00,
    MEM_SRAM  = 2'b10
  } mem_sel_e;

  typedef logic [ADDR_W-1:0]  addr_t;
  typedef logic [FIELD_W-1:0] field_t;

  function automatic logic in_low_page(input addr_t a);
    return a[ADDR_W-1:PAGE_W] == '0;
  endfunction

  function automatic addr_t join_page(input field_t f, input addr_t a);
    return {{PAD_W{1'b0}}, f, a[PAGE_W-1:0]};
  endfunction

  function automatic field_t take_field(input addr_t a);
    return a[PAGE_W+FIELD_W-1:PAGE_W];
  endfunction

  function automatic logic target_legal(input addr_t a);
    field_t f;
    logic   sel_ok;
    f      = take_field(a);
    sel_ok = (f[FIELD_W-1 -: 2] == MEM_FLASH) || (f[FIELD_W-1 -: 2] == MEM_SRAM);
    return (a[PAGE_W-1:0] == '0) && (a[ADDR_W-1:PAGE_W+FIELD_W] == '0) &&
           (f[RSV_HI:RSV_LO] == '0) && sel_ok;
  endfunction
endpackage

// File: rtl/vrm_cmd_check.sv
module vrm_cmd_check
  import vrm_pkg::*;
(
  input  addr_t  cmd_addr,
  output logic   cmd_ok,
  output field_t cmd_field
);
  always_comb begin
    cmd_ok    = target_legal(cmd_addr);
    cmd_field = take_field(cmd_addr);
  end
endmodule

// File: rtl/vrm_map_reg.sv
module vrm_map_reg
  import vrm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cmd_valid,
  input  logic   cmd_ok,
  input  field_t cmd_field,
  output field_t field_q,
  output logic   fail_q
);
  logic load_en;
  logic reject_en;

  assign load_en   = cmd_valid && cmd_ok;
  assign reject_en = cmd_valid && !cmd_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q <= '0;
      fail_q  <= 1'b0;
    end else begin
      fail_q <= reject_en;
      if (load_en) field_q <= cmd_field;
    end
  end

  assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (field_q == $past(cmd_field)) && !fail_q);

  assert_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reject_en |=> $stable(field_q) && fail_q);

  assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(field_q) && !fail_q);

  assert_rsv_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    field_q[RSV_HI:RSV_LO] == '0);

  assert_sel_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !field_q[FIELD_W-2]);
endmodule

// File: rtl/vrm_xlate.sv
module vrm_xlate
  import vrm_pkg::*;
(
  input  addr_t  bus_addr,
  input  logic   secure_hit,
  input  field_t field_q,
  output addr_t  out_addr,
  output logic   out_sram,
  output logic   remap_hit
);
  always_comb begin
    remap_hit = in_low_page(bus_addr) && !secure_hit;
    out_addr  = remap_hit ? join_page(field_q, bus_addr) : bus_addr;
    out_sram  = remap_hit && (field_q[FIELD_W-1 -: 2] == MEM_SRAM);
  end
endmodule

// File: rtl/vector_remap.sv
module vector_remap
  import vrm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] bus_addr,
  input  logic        secure_hit,
  input  logic        cmd_valid,
  input  logic [31:0] cmd_addr,
  output logic [31:0] out_addr,
  output logic        out_sram,
  output logic        cmd_fail,
  output logic [31:0] status_word
);
  logic   cmd_ok;
  field_t cmd_field;
  field_t field_q;
  logic   remap_hit;

  vrm_cmd_check u_check (
    .cmd_addr (cmd_addr),
    .cmd_ok   (cmd_ok),
    .cmd_field(cmd_field)
  );

  vrm_map_reg u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_ok   (cmd_ok),
    .cmd_field(cmd_field),
    .field_q  (field_q),
    .fail_q   (cmd_fail)
  );

  vrm_xlate u_xlate (
    .bus_addr  (bus_addr),
    .secure_hit(secure_hit),
    .field_q   (field_q),
    .out_addr  (out_addr),
    .out_sram  (out_sram),
    .remap_hit (remap_hit)
  );

  assign status_word = {{PAD_W{1'b0}}, field_q, {PAGE_W{1'b0}}};

  assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !remap_hit |-> (out_addr == bus_addr) && !out_sram);

  assert_secure_R4: assert property (@(posedge clk) disable iff (!rst_n)
    secure_hit |-> !remap_hit);
endmodule

// File: tb/test_vector_remap.sv
module test_vector_remap;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    string       tag;
    logic [31:0] a;
    logic        s;
    logic        f;
    logic [31:0] st;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        secure_hit = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_addr = '0;
  logic [31:0] out_addr;
  logic        out_sram;
  logic        cmd_fail;
  logic [31:0] status_word;

  exp_t q[$];
  int   n_checks = 0;
  int   n_fail = 0;
  logic [20:0] mf = '0;
  bit   finished = 0;

  vector_remap i_vector_remap (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .secure_hit(secure_hit),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .out_addr(out_addr),
    .out_sram(out_sram), .cmd_fail(cmd_fail), .status_word(status_word)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit model_legal(input logic [31:0] t);
    if (t % 512 != 0) return 0;
    if ((t >> 30) != 0) return 0;
    if (((t >> 21) & 32'h7F) != 0) return 0;
    if (((t >> 28) & 32'h1) != 0) return 0;
    return 1;
  endfunction

  function automatic exp_t model_out(input string tag, input bit fail);
    exp_t e;
    e.tag = tag;
    e.f   = fail;
    e.st  = 32'(mf) * 512;
    if (bus_addr < 32'h200 && !secure_hit) begin
      e.a = 32'(mf) * 512 + bus_addr;
      e.s = (mf >> 19) == 21'd2;
    end else begin
      e.a = bus_addr;
      e.s = 1'b0;
    end
    return e;
  endfunction

  task automatic do_access(input logic [31:0] a, input logic sec, input string tag);
    @(negedge clk);
    bus_addr   = a;
    secure_hit = sec;
    q.push_back(model_out(tag, 1'b0));
  endtask

  task automatic do_cmd(input logic [31:0] t, input string tag);
    bit ok;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_addr  = t;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_addr  = 32'hDEAD_BEEF;
    ok = model_legal(t);
    if (ok) mf = 21'(t / 512);
    q.push_back(model_out(tag, !ok));
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    q.push_back(model_out(tag, 1'b0));
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_checks++;
        if (out_addr !== e.a || out_sram !== e.s || cmd_fail !== e.f || status_word !== e.st) begin
          n_fail++;
          $display("FAIL %s: got addr=%h sram=%b fail=%b status=%h, expected addr=%h sram=%b fail=%b status=%h",
                   e.tag, out_addr, out_sram, cmd_fail, status_word, e.a, e.s, e.f, e.st);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    do_access(32'h0000_0000, 1'b0, "R1 reset identity low");
    do_access(32'h0000_01FC, 1'b0, "R1 reset identity top of page");
    do_access(32'h0000_0200, 1'b0, "R3 first address past page");
    do_access(32'h8000_0004, 1'b0, "R3 high address");
    do_cmd(32'h0000_4200, "R6 load flash page, R10 status");
    do_access(32'h0000_0004, 1'b0, "R2 remap flash, R5 sram=0");
    do_access(32'h0000_01FF, 1'b0, "R2 remap last byte");
    do_access(32'h0000_0010, 1'b1, "R4 secure bypass");
    do_cmd(32'h0000_4210, "R7 misaligned rejected");
    idle("R11 fail pulse ends");
    do_cmd(32'h0000_0201, "R7 low bit misaligned");
    do_cmd(32'h0020_0000, "R8 reserved bit 21");
    do_cmd(32'h0800_0000, "R8 reserved bit 27");
    do_cmd(32'h4000_0000, "R8 bit 30 set");
    do_cmd(32'h1000_0000, "R9 selector 01");
    do_cmd(32'h3000_0000, "R9 selector 11");
    do_access(32'h0000_0020, 1'b0, "R7 mapping kept after rejects");
    do_cmd(32'h2000_0400, "R6 load sram page, R10 status");
    do_access(32'h0000_0008, 1'b0, "R5 remap to sram");
    do_access(32'h0000_0300, 1'b0, "R3 outside page, sram=0");
    do_access(32'h0000_0008, 1'b1, "R4 secure bypass on sram map");
    idle("R11 no command no change");
    do_cmd(32'h0000_0000, "R6 return to identity");
    do_access(32'h0000_0044, 1'b0, "R2 identity after reload");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule